// File: doc/BRIEF.md
# Accumulator Arithmetic and Logic Unit with Carry Flag

This block is the arithmetic and logic stage of a single-accumulator processor. It holds an 8-bit accumulator and a one-bit carry/borrow flag. Each cycle it decodes the instruction byte and combines the accumulator, the flag and a memory operand byte. On a cycle where the strobe is high, it writes the new accumulator and flag. The operand may come from memory or be an immediate value. The result is the same either way, and the operand source is chosen outside this block.

Two opcode rows carry the ALU operations. The row with high nibble 7 holds the forms that consume the flag as carry in, borrow in or rotate bit. The row with high nibble F holds the plain forms. In each row, low-nibble bit 3 picks the immediate twin, except in the shift column, where it picks the direction. Subtraction is computed as addition of the inverted subtrahend. The flag is therefore 1 when no borrow occurred and 0 when one did. There are two subtract directions: operand minus accumulator, and accumulator minus operand.

Top module: `acc_alu`

## Requirements
- R1: After synchronous reset the accumulator reads 0x00 and the flag reads 0.
- R2: Opcodes 0xF4 and 0xFC load the 9-bit sum operand + accumulator into {flag, accumulator}, so the flag is the carry out.
- R3: Opcodes 0x74 and 0x7C load operand + accumulator + flag into {flag, accumulator}.
- R4: Opcodes 0xF5 and 0xFD load operand − accumulator into the accumulator, modulo 256. The flag becomes 1 when operand ≥ accumulator and 0 otherwise.
- R5: Opcodes 0xF7 and 0xFF load accumulator − operand into the accumulator, modulo 256. The flag becomes 1 when accumulator ≥ operand and 0 otherwise.
- R6: Opcodes 0x75/0x7D (operand minus accumulator) and 0x77/0x7F (accumulator minus operand) also subtract (1 − flag). The new flag is 1 exactly when the true difference is not negative.
- R7: Opcodes 0xF1/0xF9 give accumulator OR operand, 0xF2/0xFA give AND, and 0xF3/0xFB give XOR. The flag is left unchanged.
- R8: Opcode 0xF6 shifts the accumulator right, with bit 0 going to the flag and bit 7 cleared. Opcode 0xFE shifts left, with bit 7 going to the flag and bit 0 cleared.
- R9: Opcode 0x76 rotates the 9-bit ring {flag, accumulator} right: the old flag enters bit 7 and old bit 0 becomes the flag. Opcode 0x7E rotates left: the old flag enters bit 0 and old bit 7 becomes the flag.
- R10: Output is_alu is 1 for exactly the 22 opcodes named in R2 to R9. Any other opcode leaves the accumulator and flag unchanged even with the strobe high.
- R11: With the strobe low, the accumulator and flag keep their values, whatever the opcode.
- R12: Results written on a clock edge are visible on acc_q and flag_q right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| strobe | input | 1 | Commit the result of the current opcode |
| opcode | input | 8 | Instruction byte |
| operand | input | DW | Memory or immediate operand byte |
| acc_q | output | DW | Accumulator |
| flag_q | output | 1 | Carry / no-borrow flag |
| is_alu | output | 1 | Opcode is an ALU operation |

## Verification
The bench builds the block with its default width DW = 8, the only width at which the opcode semantics are defined. At that width the 9-bit carry and borrow boundaries can be reached from chosen operands: 0x80 + 0x80, and a difference of 0x00 against a borrow in. So can the full flag ring of the rotates. A pseudo-random stream then runs every ALU opcode, some foreign opcodes and idle cycles against a behavioural model that uses integer arithmetic. This mixes flag values into all the carry and borrow forms.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    typedef enum logic [2:0] {
        K_NONE,
        K_ADD,
        K_SUB_OPD,   // operand minus accumulator
        K_SUB_ACC,   // accumulator minus operand
        K_OR,
        K_AND,
        K_XOR,
        K_SHIFT
    } alu_kind_e;

    typedef struct packed {
        alu_kind_e kind;
        logic      use_flag;  // consume flag as carry, borrow or ring bit
        logic      left;      // shift direction
    } alu_ctl_t;

    localparam logic [3:0] ROW_FLAG  = 4'h7;
    localparam logic [3:0] ROW_PLAIN = 4'hF;

    function automatic alu_ctl_t decode_op(input logic [7:0] op);
        alu_ctl_t c;
        c.kind     = K_NONE;
        c.use_flag = (op[7:4] == ROW_FLAG);
        c.left     = op[3];
        if (op[7:4] == ROW_PLAIN) begin
            case (op[2:0])
                3'd1: c.kind = K_OR;
                3'd2: c.kind = K_AND;
                3'd3: c.kind = K_XOR;
                3'd4: c.kind = K_ADD;
                3'd5: c.kind = K_SUB_OPD;
                3'd6: c.kind = K_SHIFT;
                3'd7: c.kind = K_SUB_ACC;
                default: c.kind = K_NONE;
            endcase
        end else if (op[7:4] == ROW_FLAG) begin
            case (op[2:0])
                3'd4: c.kind = K_ADD;
                3'd5: c.kind = K_SUB_OPD;
                3'd6: c.kind = K_SHIFT;
                3'd7: c.kind = K_SUB_ACC;
                default: c.kind = K_NONE;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/acc_alu_decode.sv
module acc_alu_decode
    import acc_alu_pkg::*;
(
    input  logic [7:0] opcode,
    output alu_ctl_t   ctl,
    output logic       valid
);
    always_comb begin
        ctl   = decode_op(opcode);
        valid = (ctl.kind != K_NONE);
    end
endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
    import acc_alu_pkg::*;
#(
    parameter int DW = 8
) (
    input  alu_ctl_t        ctl,
    input  logic [DW-1:0]   acc,
    input  logic            flag,
    input  logic [DW-1:0]   operand,
    output logic [DW-1:0]   res,
    output logic            res_flag,
    output logic            flag_wr
);
    localparam int SW = DW + 1;

    logic [DW-1:0] add_a;
    logic [DW-1:0] add_b;
    logic          add_cin;
    logic [SW-1:0] sum;
    logic          ring_in;

    // One adder serves both add and both subtract directions.
    always_comb begin
        add_a   = operand;
        add_b   = acc;
        add_cin = ctl.use_flag ? flag : 1'b0;
        case (ctl.kind)
            K_SUB_OPD: begin
                add_a   = operand;
                add_b   = ~acc;
                add_cin = ctl.use_flag ? flag : 1'b1;
            end
            K_SUB_ACC: begin
                add_a   = acc;
                add_b   = ~operand;
                add_cin = ctl.use_flag ? flag : 1'b1;
            end
            default: ;
        endcase
        sum = {1'b0, add_a} + {1'b0, add_b} + {{(SW-1){1'b0}}, add_cin};
    end

    always_comb begin
        ring_in  = ctl.use_flag ? flag : 1'b0;
        res      = acc;
        res_flag = flag;
        flag_wr  = 1'b0;
        case (ctl.kind)
            K_ADD, K_SUB_OPD, K_SUB_ACC: begin
                res      = sum[DW-1:0];
                res_flag = sum[DW];
                flag_wr  = 1'b1;
            end
            K_OR:  res = acc | operand;
            K_AND: res = acc & operand;
            K_XOR: res = acc ^ operand;
            K_SHIFT: begin
                flag_wr = 1'b1;
                if (ctl.left) begin
                    res      = {acc[DW-2:0], ring_in};
                    res_flag = acc[DW-1];
                end else begin
                    res      = {ring_in, acc[DW-1:1]};
                    res_flag = acc[0];
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/acc_alu_state.sv
module acc_alu_state #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_acc,
    input  logic          wr_flag,
    input  logic [DW-1:0] acc_d,
    input  logic          flag_d,
    output logic [DW-1:0] acc_q,
    output logic          flag_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            if (wr_acc)  acc_q  <= acc_d;
            if (wr_flag) flag_q <= flag_d;
        end
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          strobe,
    input  logic [7:0]    opcode,
    input  logic [DW-1:0] operand,
    output logic [DW-1:0] acc_q,
    output logic          flag_q,
    output logic          is_alu
);
    alu_ctl_t      ctl;
    logic          valid;
    logic [DW-1:0] res;
    logic          res_flag;
    logic          flag_wr;

    acc_alu_decode u_dec (
        .opcode (opcode),
        .ctl    (ctl),
        .valid  (valid)
    );

    acc_alu_core #(.DW(DW)) u_core (
        .ctl      (ctl),
        .acc      (acc_q),
        .flag     (flag_q),
        .operand  (operand),
        .res      (res),
        .res_flag (res_flag),
        .flag_wr  (flag_wr)
    );

    acc_alu_state #(.DW(DW)) u_state (
        .clk     (clk),
        .rst     (rst),
        .wr_acc  (strobe && valid),
        .wr_flag (strobe && valid && flag_wr),
        .acc_d   (res),
        .flag_d  (res_flag),
        .acc_q   (acc_q),
        .flag_q  (flag_q)
    );

    assign is_alu = valid;
endmodule

// File: rtl/acc_alu_checker.sv
module acc_alu_checker #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          strobe,
    input logic [7:0]    opcode,
    input logic [DW-1:0] operand,
    input logic [DW-1:0] acc_q,
    input logic          flag_q,
    input logic          is_alu
);
    logic logic_op;
    assign logic_op = (opcode == 8'hF1) || (opcode == 8'hF2) || (opcode == 8'hF3) ||
                      (opcode == 8'hF9) || (opcode == 8'hFA) || (opcode == 8'hFB);

    assert_reset_R1: assert property (@(posedge clk)
        $past(rst) |-> (acc_q == '0) && !flag_q);

    assert_add_R2: assert property (@(posedge clk) disable iff (rst)
        strobe && opcode == 8'hF4 |=>
            {flag_q, acc_q} == ({1'b0, $past(operand)} + {1'b0, $past(acc_q)}));

    assert_logic_flag_R7: assert property (@(posedge clk) disable iff (rst)
        strobe && logic_op |=> $stable(flag_q));

    assert_shr_R8: assert property (@(posedge clk) disable iff (rst)
        strobe && opcode == 8'hF6 |=> !acc_q[DW-1] && flag_q == $past(acc_q[0]));

    assert_rotr_R9: assert property (@(posedge clk) disable iff (rst)
        strobe && opcode == 8'h76 |=>
            acc_q[DW-1] == $past(flag_q) && flag_q == $past(acc_q[0]));

    assert_foreign_R10: assert property (@(posedge clk) disable iff (rst)
        strobe && !is_alu |=> $stable(acc_q) && $stable(flag_q));

    assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !strobe |=> $stable(acc_q) && $stable(flag_q));
endmodule

bind acc_alu acc_alu_checker #(.DW(DW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .opcode  (opcode),
    .operand (operand),
    .acc_q   (acc_q),
    .flag_q  (flag_q),
    .is_alu  (is_alu)
);

// File: tb/test_acc_alu.sv
module test_acc_alu;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       strobe = 1'b0;
    logic [7:0] opcode = 8'h00;
    logic [7:0] operand = 8'h00;
    logic [7:0] acc_q;
    logic       flag_q;
    logic       is_alu;

    int compared = 0;
    int mismatched = 0;
    int m_acc = 0;
    int m_flag = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    acc_alu i_acc_alu (
        .clk     (clk),
        .rst     (rst),
        .strobe  (strobe),
        .opcode  (opcode),
        .operand (operand),
        .acc_q   (acc_q),
        .flag_q  (flag_q),
        .is_alu  (is_alu)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            mismatched = mismatched + 1;
            $display("FAIL watchdog: actual=%0d cycles expected=done", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    function automatic bit ref_is_alu(int op);
        int hi = op / 16;
        int lo = op % 16;
        if (hi == 15) return (lo != 0) && (lo != 8);
        if (hi == 7)  return (lo % 8) >= 4;
        return 0;
    endfunction

    function automatic string req_of(int op);
        case (op)
            'hF4, 'hFC: return "R2";
            'h74, 'h7C: return "R3";
            'hF5, 'hFD: return "R4";
            'hF7, 'hFF: return "R5";
            'h75, 'h7D, 'h77, 'h7F: return "R6";
            'hF1, 'hF9, 'hF2, 'hFA, 'hF3, 'hFB: return "R7";
            'hF6, 'hFE: return "R8";
            'h76, 'h7E: return "R9";
            default: return "R10";
        endcase
    endfunction

    // Behavioural model: integer arithmetic on the accumulator and flag.
    task automatic model_step(int op, int v);
        int r;
        case (op)
            'hF4, 'hFC: begin r = v + m_acc;            m_flag = r / 256; m_acc = r % 256; end
            'h74, 'h7C: begin r = v + m_acc + m_flag;   m_flag = r / 256; m_acc = r % 256; end
            'hF5, 'hFD: begin r = v - m_acc;            m_flag = (r >= 0); m_acc = (r + 512) % 256; end
            'hF7, 'hFF: begin r = m_acc - v;            m_flag = (r >= 0); m_acc = (r + 512) % 256; end
            'h75, 'h7D: begin r = v - m_acc - (1 - m_flag); m_flag = (r >= 0); m_acc = (r + 512) % 256; end
            'h77, 'h7F: begin r = m_acc - v - (1 - m_flag); m_flag = (r >= 0); m_acc = (r + 512) % 256; end
            'hF1, 'hF9: m_acc = m_acc | v;
            'hF2, 'hFA: m_acc = m_acc & v;
            'hF3, 'hFB: m_acc = m_acc ^ v;
            'hF6: begin m_flag = m_acc % 2; m_acc = m_acc / 2; end
            'hFE: begin m_flag = m_acc / 128; m_acc = (m_acc * 2) % 256; end
            'h76: begin r = m_acc % 2; m_acc = m_acc / 2 + 128 * m_flag; m_flag = r; end
            'h7E: begin r = m_acc / 128; m_acc = (m_acc * 2) % 256 + m_flag; m_flag = r; end
            default: ;
        endcase
    endtask

    task automatic check(string req, string what, int actual, int expected);
        compared = compared + 1;
        if (actual != expected) begin
            mismatched = mismatched + 1;
            $display("FAIL %s %s: actual=%02h expected=%02h", req, what, actual, expected);
        end
    endtask

    // Inputs change on the falling edge; results are read on the next falling edge (R12).
    task automatic step(int op, int v, bit stb, string req);
        opcode  = op[7:0];
        operand = v[7:0];
        strobe  = stb;
        #1;
        check("R10", "is_alu", int'(is_alu), int'(ref_is_alu(op)));
        if (stb) model_step(op, v);
        @(negedge clk);
        check(req, "acc", int'(acc_q), m_acc);
        check(req, "flag", int'(flag_q), m_flag);
    endtask

    task automatic run(int op, int v);
        step(op, v, 1'b1, req_of(op));
    endtask

    task automatic set_acc(int v);
        run('hF2, 0);
        run('hF1, v);
    endtask

    task automatic set_flag(int f);
        set_acc(f * 128);
        run('hFE, 0);
    endtask

    initial begin
        int lfsr = 'hACE1;
        repeat (3) @(negedge clk);
        check("R1", "acc", int'(acc_q), 0);
        check("R1", "flag", int'(flag_q), 0);
        rst = 1'b0;

        set_acc('h80); run('hF4, 'h80);   // carry out, zero result
        set_acc('h12); run('hFC, 'h34);
        set_flag(1); set_acc('hFF); run('h74, 'h00);
        set_flag(1); set_acc('h10); run('h7C, 'h20);
        set_acc('h20); run('hF5, 'h10);   // operand < acc: borrow
        set_acc('h20); run('hFD, 'h20);   // equal: no borrow
        set_acc('h10); run('hF7, 'h20);
        set_acc('h33); run('hFF, 'h11);
        set_flag(0); set_acc('h05); run('h75, 'h05);  // 0 - 1 borrow
        set_flag(1); set_acc('h05); run('h7D, 'h05);
        set_flag(0); set_acc('h40); run('h77, 'h3F);  // exactly zero
        set_flag(0); set_acc('h40); run('h7F, 'h40);
        set_flag(1); set_acc('hF0); run('hF1, 'h0F); run('hFA, 'h3C); run('hF3, 'hFF);
        set_flag(0); set_acc('h55); run('hF9, 'hAA); run('hF2, 'h81); run('hFB, 'h01);
        set_flag(1); set_acc('h81); run('hF6, 0);
        set_flag(0); set_acc('h81); run('hFE, 0);
        set_flag(1); set_acc('h02); run('h76, 0); run('h76, 0);
        set_flag(1); set_acc('h80); run('h7E, 0); run('h7E, 0);
        set_acc('h5A);
        run('h00, 'hFF); run('h30, 'h12); run('hC4, 'h00); run('hF8, 'h77);
        run('hF0, 'h77); run('h68, 'h01); run('h70, 'h01); run('h7B, 'h01);
        step('hF4, 'hFF, 1'b0, "R11"); step('h76, 'h00, 1'b0, "R11");

        for (int i = 0; i < 600; i++) begin
            int op;
            int bitv;
            bitv = ((lfsr >> 0) ^ (lfsr >> 2) ^ (lfsr >> 3) ^ (lfsr >> 5)) & 1;
            lfsr = (lfsr >> 1) | (bitv << 15);
            op = (lfsr % 3 == 0) ? ('h70 + lfsr % 16) : ('hF0 + (lfsr / 16) % 16);
            step(op, (lfsr / 256) % 256, (lfsr % 7) != 0,
                 ((lfsr % 7) != 0) ? req_of(op) : "R11");
        end

        rst = 1'b1;
        @(negedge clk);
        check("R1", "acc", int'(acc_q), 0);
        check("R1", "flag", int'(flag_q), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule